// File: doc/BRIEF.md
# Virtual Interrupt Priority Engine

This block keeps the virtual interrupt state of one guest processor for 256 vectors: a request bitmap, an in-service bitmap, the highest requesting vector, the vector being serviced, the derived processor priority and the task priority. Priority is decided by class, the upper four bits of a vector, so a request only becomes pending when its class is above the class of the processor priority.

A single command port accepts four operations: deliver the current request, end-of-interrupt, self-interrupt of a given vector, and task-priority update. Deliver and end-of-interrupt each need a highest-set-bit rescan of a bitmap. The rescan reads one 32-bit word per cycle from the top word down, and `busy` holds off further commands until it ends. The outputs are a pending flag, a one-cycle delivery strobe with its vector, and two one-cycle exit strobes (end-of-interrupt exit and threshold exit) that share one qualification field. A per-vector end-of-interrupt exit map, a threshold, a delivery-enable bit and an interrupt-window bit come in as configuration.

Top module: `vipe_engine`

## Requirements
- R1: After reset, all bitmaps, `rvi_o`, `svi_o`, `ppr_o`, `tpr_o`, `pend`, `busy` and every strobe read zero.
- R2: Whenever pending evaluation runs, `pend` becomes 1 exactly when `cfg_win_exit` is 0 and `rvi_o[7:4]` is greater than `ppr_o[7:4]`. Otherwise it becomes 0.
- R3: Deliver (`cmd_op`=0) pulses `deliv_valid` with `deliv_vec` equal to the old request vector. It sets that vector's in-service bit, sets `svi_o` to it, sets `ppr_o` to its class with the low nibble zero, clears `pend`, clears its request bit, and then sets `rvi_o` to the highest remaining request vector, or 0 if none remains.
- R4: End-of-interrupt (`cmd_op`=1) clears the in-service bit of `svi_o`, sets `svi_o` to the highest remaining in-service vector (0 if none), and recomputes `ppr_o`.
- R5: A recomputed `ppr_o` equals `tpr_o` when `tpr_o[7:4]` is at least `svi_o[7:4]`, and `{svi_o[7:4],4'h0}` otherwise.
- R6: After an end-of-interrupt, if bit `old` of `cfg_eoi_exit_map` is set (where `old` is the retired vector), `exit_eoi` pulses with `exit_qual` = `old` and `pend` is left unchanged. Otherwise pending evaluation runs.
- R7: Self-interrupt (`cmd_op`=2, vector `cmd_vec`) sets that request bit, replaces `rvi_o` with `cmd_vec` when `cmd_vec` >= `rvi_o`, and then runs pending evaluation against the unchanged `ppr_o`.
- R8: Task-priority update (`cmd_op`=3) stores `cmd_vec` in `tpr_o`. With `cfg_vid_en` = 0 it leaves `ppr_o` and `pend` alone, and pulses `exit_thr` with `exit_qual` = 0 when `cmd_vec[7:4]` < `cfg_thresh`.
- R9: With `cfg_vid_en` = 1, a task-priority update recomputes `ppr_o` by R5, runs pending evaluation and raises no exit.
- R10: Vector v lives in bitmap word v/32, bit v%32. A rescan keeps `busy` high for 8-w cycles, where w is the highest non-empty word, and for 8 cycles when the bitmap is empty.
- R11: A command presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_vid_en | input | 1 | Virtual delivery enabled; selects the task-priority behaviour |
| cfg_win_exit | input | 1 | Interrupt-window exiting active; forces pending to 0 |
| cfg_thresh | input | 4 | Task-priority class threshold |
| cfg_eoi_exit_map | input | 256 | Per-vector end-of-interrupt exit select |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 deliver, 1 end-of-interrupt, 2 self-interrupt, 3 task priority |
| cmd_vec | input | 8 | Vector for a self-interrupt, or the new task priority |
| busy | output | 1 | Rescan in progress; commands are ignored |
| pend | output | 1 | Virtual interrupt pending |
| deliv_valid | output | 1 | One-cycle delivery strobe |
| deliv_vec | output | 8 | Delivered vector |
| exit_eoi | output | 1 | One-cycle end-of-interrupt exit strobe |
| exit_thr | output | 1 | One-cycle threshold exit strobe |
| exit_qual | output | 8 | Exit qualification |
| rvi_o | output | 8 | Requesting vector |
| svi_o | output | 8 | Servicing vector |
| ppr_o | output | 8 | Processor priority |
| tpr_o | output | 8 | Task priority |

## Verification
The bench builds the engine with its defaults: 256 vectors in eight 32-bit words and 4-bit classes. All sixteen priority classes and every rescan length from one to eight cycles are therefore reachable. Random self-interrupts spread across all words and are sometimes held to the lowest word, so that rescans run to their longest. Directed cases add an empty-bitmap deliver, a command injected during a rescan, threshold exits with delivery disabled, and pending evaluation under interrupt-window exiting.

// File: rtl/vipe_pkg.sv
package vipe_pkg;
  typedef enum logic [1:0] {
    OP_DELIVER = 2'd0,
    OP_EOI     = 2'd1,
    OP_SELF    = 2'd2,
    OP_TPR     = 2'd3
  } vipe_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } vipe_state_e;

  typedef enum logic {
    TGT_REQ = 1'b0,
    TGT_SRV = 1'b1
  } vipe_tgt_e;
endpackage

// File: rtl/vipe_bitmap.sv
module vipe_bitmap #(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               set_en,
  input  logic                               clr_en,
  input  logic [$clog2(NUM_VEC)-1:0]         wr_vec,
  input  logic [$clog2(NUM_VEC/WORD_W)-1:0]  rd_idx,
  output logic [WORD_W-1:0]                  rd_word
);
  localparam int VEC_W = $clog2(NUM_VEC);
  localparam int WORDS = NUM_VEC / WORD_W;
  localparam int BIT_W = $clog2(WORD_W);
  localparam int IDX_W = $clog2(WORDS);

  logic [WORD_W-1:0] words_q [WORDS];
  logic [IDX_W-1:0]  w_idx;
  logic [BIT_W-1:0]  w_bit;
  logic [WORD_W-1:0] w_mask;

  assign w_idx  = wr_vec[VEC_W-1:BIT_W];
  assign w_bit  = wr_vec[BIT_W-1:0];
  assign w_mask = WORD_W'(1) << w_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int w = 0; w < WORDS; w++) words_q[w] <= '0;
    end else if (set_en) begin
      words_q[w_idx] <= words_q[w_idx] | w_mask;
    end else if (clr_en) begin
      words_q[w_idx] <= words_q[w_idx] & ~w_mask;
    end
  end

  assign rd_word = words_q[rd_idx];

  // R3: deliver sets one bitmap and clears the other, never both on one
  always @(posedge clk) begin
    if (!rst) begin
      p_single_write_r3: assert (!(set_en && clr_en));
    end
  end
endmodule

// File: rtl/vipe_msb.sv
module vipe_msb #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0]         word,
  output logic                      found,
  output logic [$clog2(WORD_W)-1:0] pos
);
  localparam int BIT_W = $clog2(WORD_W);

  always_comb begin
    found = 1'b0;
    pos   = '0;
    for (int b = 0; b < WORD_W; b++) begin
      if (word[b]) begin
        found = 1'b1;
        pos   = BIT_W'(b);
      end
    end
  end
endmodule

// File: rtl/vipe_prio.sv
module vipe_prio #(
  parameter int VEC_W   = 8,
  parameter int CLASS_W = 4
) (
  input  logic [VEC_W-1:0] tpr_i,
  input  logic [VEC_W-1:0] svi_i,
  input  logic [VEC_W-1:0] rvi_i,
  input  logic [VEC_W-1:0] ppr_ref_i,
  input  logic             win_exit_i,
  output logic [VEC_W-1:0] ppr_o,
  output logic             pend_o
);
  localparam int SUB_W = VEC_W - CLASS_W;

  logic [CLASS_W-1:0] tpr_cls, svi_cls, rvi_cls, ref_cls;

  assign tpr_cls = tpr_i[VEC_W-1:SUB_W];
  assign svi_cls = svi_i[VEC_W-1:SUB_W];
  assign rvi_cls = rvi_i[VEC_W-1:SUB_W];
  assign ref_cls = ppr_ref_i[VEC_W-1:SUB_W];

  always_comb begin
    if (tpr_cls >= svi_cls) ppr_o = tpr_i;
    else                    ppr_o = {svi_cls, {SUB_W{1'b0}}};
  end

  assign pend_o = !win_exit_i && (rvi_cls > ref_cls);
endmodule

// File: rtl/vipe_engine.sv
module vipe_engine
  import vipe_pkg::*;
#(
  parameter int NUM_VEC = 256,
  parameter int WORD_W  = 32,
  parameter int CLASS_W = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       cfg_vid_en,
  input  logic                       cfg_win_exit,
  input  logic [CLASS_W-1:0]         cfg_thresh,
  input  logic [NUM_VEC-1:0]         cfg_eoi_exit_map,
  input  logic                       cmd_valid,
  input  logic [1:0]                 cmd_op,
  input  logic [$clog2(NUM_VEC)-1:0] cmd_vec,
  output logic                       busy,
  output logic                       pend,
  output logic                       deliv_valid,
  output logic [$clog2(NUM_VEC)-1:0] deliv_vec,
  output logic                       exit_eoi,
  output logic                       exit_thr,
  output logic [$clog2(NUM_VEC)-1:0] exit_qual,
  output logic [$clog2(NUM_VEC)-1:0] rvi_o,
  output logic [$clog2(NUM_VEC)-1:0] svi_o,
  output logic [$clog2(NUM_VEC)-1:0] ppr_o,
  output logic [$clog2(NUM_VEC)-1:0] tpr_o
);
  localparam int VEC_W = $clog2(NUM_VEC);
  localparam int WORDS = NUM_VEC / WORD_W;
  localparam int IDX_W = $clog2(WORDS);
  localparam int BIT_W = $clog2(WORD_W);
  localparam int SUB_W = VEC_W - CLASS_W;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WORDS - 1);

  vipe_state_e      state_q;
  vipe_tgt_e        tgt_q;
  logic [IDX_W-1:0] idx_q;
  logic [VEC_W-1:0] old_q;
  logic [VEC_W-1:0] rvi_q, svi_q, ppr_q, tpr_q;
  logic             pend_q;
  logic             dv_q, xeoi_q, xthr_q;
  logic [VEC_W-1:0] dvec_q, xqual_q;

  vipe_op_e op;
  logic     accept;
  assign op     = vipe_op_e'(cmd_op);
  assign accept = cmd_valid && (state_q == ST_IDLE);

  // request and in-service bitmaps
  logic [WORD_W-1:0] req_word, srv_word;
  logic [VEC_W-1:0]  req_wvec, srv_wvec;
  assign req_wvec = (op == OP_SELF) ? cmd_vec : rvi_q;
  assign srv_wvec = (op == OP_DELIVER) ? rvi_q : svi_q;

  vipe_bitmap #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_req (
    .clk(clk), .rst(rst),
    .set_en (accept && op == OP_SELF),
    .clr_en (accept && op == OP_DELIVER),
    .wr_vec (req_wvec),
    .rd_idx (idx_q),
    .rd_word(req_word)
  );

  vipe_bitmap #(.NUM_VEC(NUM_VEC), .WORD_W(WORD_W)) u_srv (
    .clk(clk), .rst(rst),
    .set_en (accept && op == OP_DELIVER),
    .clr_en (accept && op == OP_EOI),
    .wr_vec (srv_wvec),
    .rd_idx (idx_q),
    .rd_word(srv_word)
  );

  // one-word-per-cycle highest-bit scan
  logic [WORD_W-1:0] scan_word;
  logic              scan_hit;
  logic [BIT_W-1:0]  scan_pos;
  logic              scan_done;
  logic [VEC_W-1:0]  scan_vec;

  assign scan_word = (tgt_q == TGT_SRV) ? srv_word : req_word;

  vipe_msb #(.WORD_W(WORD_W)) u_msb (
    .word (scan_word),
    .found(scan_hit),
    .pos  (scan_pos)
  );

  assign scan_done = (state_q == ST_SCAN) && (scan_hit || idx_q == '0);
  assign scan_vec  = scan_hit ? {idx_q, scan_pos} : '0;

  // priority and pending evaluation
  logic             eoi_fin, tpr_cmd, self_cmd;
  logic [VEC_W-1:0] rvi_self, ppr_new;
  logic             pend_new;

  assign eoi_fin  = scan_done && (tgt_q == TGT_SRV);
  assign tpr_cmd  = accept && op == OP_TPR;
  assign self_cmd = accept && op == OP_SELF;
  assign rvi_self = (cmd_vec >= rvi_q) ? cmd_vec : rvi_q;

  vipe_prio #(.VEC_W(VEC_W), .CLASS_W(CLASS_W)) u_prio (
    .tpr_i     (tpr_cmd ? cmd_vec : tpr_q),
    .svi_i     (eoi_fin ? scan_vec : svi_q),
    .rvi_i     (self_cmd ? rvi_self : rvi_q),
    .ppr_ref_i (self_cmd ? ppr_q : ppr_new),
    .win_exit_i(cfg_win_exit),
    .ppr_o     (ppr_new),
    .pend_o    (pend_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      tgt_q   <= TGT_REQ;
      idx_q   <= '0;
      old_q   <= '0;
      rvi_q   <= '0;
      svi_q   <= '0;
      ppr_q   <= '0;
      tpr_q   <= '0;
      pend_q  <= 1'b0;
      dv_q    <= 1'b0;
      dvec_q  <= '0;
      xeoi_q  <= 1'b0;
      xthr_q  <= 1'b0;
      xqual_q <= '0;
    end else begin
      dv_q   <= 1'b0;
      xeoi_q <= 1'b0;
      xthr_q <= 1'b0;
      if (accept) begin
        unique case (op)
          OP_DELIVER: begin
            dv_q    <= 1'b1;
            dvec_q  <= rvi_q;
            svi_q   <= rvi_q;
            ppr_q   <= {rvi_q[VEC_W-1:SUB_W], {SUB_W{1'b0}}};
            pend_q  <= 1'b0;
            state_q <= ST_SCAN;
            tgt_q   <= TGT_REQ;
            idx_q   <= TOP_IDX;
          end
          OP_EOI: begin
            old_q   <= svi_q;
            state_q <= ST_SCAN;
            tgt_q   <= TGT_SRV;
            idx_q   <= TOP_IDX;
          end
          OP_SELF: begin
            rvi_q  <= rvi_self;
            pend_q <= pend_new;
          end
          OP_TPR: begin
            tpr_q <= cmd_vec;
            if (cfg_vid_en) begin
              ppr_q  <= ppr_new;
              pend_q <= pend_new;
            end else if (cmd_vec[VEC_W-1:SUB_W] < cfg_thresh) begin
              xthr_q  <= 1'b1;
              xqual_q <= '0;
            end
          end
          default: ;
        endcase
      end else if (state_q == ST_SCAN) begin
        if (scan_done) begin
          state_q <= ST_IDLE;
          if (tgt_q == TGT_REQ) begin
            rvi_q <= scan_vec;
          end else begin
            svi_q <= scan_vec;
            ppr_q <= ppr_new;
            if (cfg_eoi_exit_map[old_q]) begin
              xeoi_q  <= 1'b1;
              xqual_q <= old_q;
            end else begin
              pend_q <= pend_new;
            end
          end
        end else begin
          idx_q <= idx_q - 1'b1;
        end
      end
    end
  end

  assign busy        = (state_q == ST_SCAN);
  assign pend        = pend_q;
  assign deliv_valid = dv_q;
  assign deliv_vec   = dvec_q;
  assign exit_eoi    = xeoi_q;
  assign exit_thr    = xthr_q;
  assign exit_qual   = xqual_q;
  assign rvi_o       = rvi_q;
  assign svi_o       = svi_q;
  assign ppr_o       = ppr_q;
  assign tpr_o       = tpr_q;

  // R11: a command during a rescan leaves the task priority untouched
  p_busy_ignore_r11: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_valid) |=> $stable(tpr_q));

  // R3: deliver drops priority to the delivered class and clears pending
  p_deliver_ppr_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_DELIVER) |=>
      (ppr_q == {$past(rvi_q[VEC_W-1:SUB_W]), {SUB_W{1'b0}}}) && !pend_q && busy);

  // R7: after a self-interrupt the request vector is at least the new vector
  p_self_rvi_r7: assert property (@(posedge clk) disable iff (rst)
    (accept && op == OP_SELF) |=> (rvi_q >= $past(cmd_vec)));

  // R8: a threshold exit only follows an accepted task-priority update
  p_thr_source_r8: assert property (@(posedge clk) disable iff (rst)
    exit_thr |-> ($past(accept) && $past(op == OP_TPR) && $past(!cfg_vid_en)));

  // R6: the two exit strobes never coincide
  p_exit_excl_r6: assert property (@(posedge clk) disable iff (rst)
    $countones({exit_eoi, exit_thr}) <= 1);

  // R5: a recomputed priority class is never below task or servicing class
  p_ppr_floor_r5: assert property (@(posedge clk) disable iff (rst)
    eoi_fin |=> (ppr_q[VEC_W-1:SUB_W] >= tpr_q[VEC_W-1:SUB_W]) &&
               (ppr_q[VEC_W-1:SUB_W] >= svi_q[VEC_W-1:SUB_W]));

  // R10: a reported hit points at a set bit of the scanned word
  p_scan_hit_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && scan_hit) |-> scan_word[scan_pos]);
endmodule

// File: tb/vipe_engine_tb_top.sv
`timescale 1ns/1ps
module vipe_engine_tb_top;
  localparam int NV = 256;
  localparam int WW = 32;
  localparam int NW = NV / WW;

  logic         clk = 1'b0;
  logic         rst;
  logic         cfg_vid_en, cfg_win_exit;
  logic [3:0]   cfg_thresh;
  logic [NV-1:0] cfg_eoi_exit_map;
  logic         cmd_valid;
  logic [1:0]   cmd_op;
  logic [7:0]   cmd_vec;
  logic         busy, pend, deliv_valid, exit_eoi, exit_thr;
  logic [7:0]   deliv_vec, exit_qual, rvi_o, svi_o, ppr_o, tpr_o;

  always #2.5 clk = ~clk;

  vipe_engine dut_i (
    .clk(clk), .rst(rst),
    .cfg_vid_en(cfg_vid_en), .cfg_win_exit(cfg_win_exit),
    .cfg_thresh(cfg_thresh), .cfg_eoi_exit_map(cfg_eoi_exit_map),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_vec(cmd_vec),
    .busy(busy), .pend(pend), .deliv_valid(deliv_valid), .deliv_vec(deliv_vec),
    .exit_eoi(exit_eoi), .exit_thr(exit_thr), .exit_qual(exit_qual),
    .rvi_o(rvi_o), .svi_o(svi_o), .ppr_o(ppr_o), .tpr_o(tpr_o)
  );

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference state
  logic [NV-1:0] m_irr, m_isr;
  logic [7:0]    m_rvi, m_svi, m_ppr, m_tpr;
  logic          m_pend;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] hi_vec(input logic [NV-1:0] b);
    logic [7:0] r = 8'h00;
    for (int i = 0; i < NV; i++) if (b[i]) r = 8'(i);
    return r;
  endfunction

  function automatic int scan_len(input logic [NV-1:0] b);
    for (int w = NW - 1; w >= 0; w--)
      if (b[w*WW +: WW] != '0) return NW - w;
    return NW;
  endfunction

  function automatic logic [7:0] ppr_of(input logic [7:0] t, input logic [7:0] s);
    return (t[7:4] >= s[7:4]) ? t : {s[7:4], 4'h0};
  endfunction

  function automatic logic pend_of(input logic [7:0] r, input logic [7:0] p);
    return !cfg_win_exit && (r[7:4] > p[7:4]);
  endfunction

  // issue one command; poke injects a task-priority command mid-rescan
  task automatic run_cmd(input logic [1:0] op, input logic [7:0] v, input bit poke);
    logic       e_dv = 0, e_xe = 0, e_xt = 0;
    logic [7:0] e_dvec = 0, e_q = 0, old;
    int         e_len = 0, n = 0;
    case (op)
      2'd0: begin
        e_dv = 1; e_dvec = m_rvi;
        m_isr[m_rvi] = 1'b1; m_irr[m_rvi] = 1'b0;
        m_svi = m_rvi; m_ppr = {m_rvi[7:4], 4'h0}; m_pend = 0;
        e_len = scan_len(m_irr); m_rvi = hi_vec(m_irr);
      end
      2'd1: begin
        old = m_svi; m_isr[old] = 1'b0;
        e_len = scan_len(m_isr); m_svi = hi_vec(m_isr);
        m_ppr = ppr_of(m_tpr, m_svi);
        if (cfg_eoi_exit_map[old]) begin e_xe = 1; e_q = old; end
        else m_pend = pend_of(m_rvi, m_ppr);
      end
      2'd2: begin
        m_irr[v] = 1'b1;
        if (v >= m_rvi) m_rvi = v;
        m_pend = pend_of(m_rvi, m_ppr);
      end
      default: begin
        m_tpr = v;
        if (cfg_vid_en) begin
          m_ppr = ppr_of(m_tpr, m_svi);
          m_pend = pend_of(m_rvi, m_ppr);
        end else if (v[7:4] < cfg_thresh) e_xt = 1;
      end
    endcase
    cmd_valid = 1; cmd_op = op; cmd_vec = v;
    @(negedge clk);
    cmd_valid = 0;
    chk("R3 deliv_valid", deliv_valid, e_dv);
    if (e_dv) chk("R3 deliv_vec", deliv_vec, e_dvec);
    while (busy && n < 20) begin
      n++;
      if (poke && n == 1) begin
        cmd_valid = 1; cmd_op = 2'd3; cmd_vec = 8'hEE;
      end else cmd_valid = 0;
      @(negedge clk);
    end
    cmd_valid = 0;
    chk("R10 busy cycles", n, e_len);
    chk("R6 exit_eoi", exit_eoi, e_xe);
    chk("R8 exit_thr", exit_thr, e_xt);
    if (e_xe || e_xt) chk("R6/R8 exit_qual", exit_qual, e_q);
    chk("R3/R7 rvi", rvi_o, m_rvi);
    chk("R4 svi", svi_o, m_svi);
    chk("R5 ppr", ppr_o, m_ppr);
    chk("R8/R11 tpr", tpr_o, m_tpr);
    chk("R2 pend", pend, m_pend);
  endtask

  initial begin
    #(5ns * 190000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int r;
    void'($urandom(32'h1357_2468));
    rst = 1; cmd_valid = 0; cmd_op = 0; cmd_vec = 0;
    cfg_vid_en = 1; cfg_win_exit = 0; cfg_thresh = 4'h0; cfg_eoi_exit_map = '0;
    m_irr = '0; m_isr = '0; m_rvi = 0; m_svi = 0; m_ppr = 0; m_tpr = 0; m_pend = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 pend", pend, 0);
    chk("R1 strobes", {deliv_valid, exit_eoi, exit_thr}, 0);
    chk("R1 regs", {rvi_o, svi_o, ppr_o, tpr_o}, 0);

    // R10 deliver with empty request bitmap scans all eight words
    run_cmd(2'd0, 8'h00, 0);
    // R11 poke during an empty in-service rescan after clearing vector 0
    run_cmd(2'd1, 8'h00, 1);
    // R7 R2 self-interrupt raises pending, then window exiting masks it
    run_cmd(2'd2, 8'h45, 0);
    cfg_win_exit = 1;
    run_cmd(2'd2, 8'h30, 0);
    cfg_win_exit = 0;
    run_cmd(2'd2, 8'hE1, 0);
    run_cmd(2'd0, 8'h00, 0);
    // R6 exit on end-of-interrupt of 0xE1
    cfg_eoi_exit_map[8'hE1] = 1'b1;
    run_cmd(2'd1, 8'h00, 0);
    // R8 threshold exit with delivery disabled, then no exit at the threshold
    cfg_vid_en = 0; cfg_thresh = 4'h6;
    run_cmd(2'd3, 8'h5F, 0);
    run_cmd(2'd3, 8'h60, 0);
    cfg_vid_en = 1;
    // R9 task priority recomputes priority
    run_cmd(2'd3, 8'h72, 0);
    run_cmd(2'd3, 8'h10, 0);

    // constrained random phase
    for (int i = 0; i < 1500; i++) begin
      if (i % 100 == 0) begin
        for (int k = 0; k < NW; k++) cfg_eoi_exit_map[k*WW +: WW] = $urandom;
        cfg_vid_en   = ($urandom % 8) != 0;
        cfg_win_exit = ($urandom % 10) == 0;
        cfg_thresh   = 4'($urandom);
      end
      r = $urandom % 10;
      if (r < 4) begin
        v = (($urandom % 4) == 0) ? 8'($urandom % 32) : 8'($urandom);
        run_cmd(2'd2, v, 0);
      end else if (r < 6) run_cmd(2'd0, 8'h00, 0);
      else if (r < 8) run_cmd(2'd1, 8'h00, 0);
      else run_cmd(2'd3, 8'($urandom), 0);
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule